// File: doc/BRIEF.md
# SPI Serial Clock Divider with Linear and Power-of-Two Laws

This block derives the serial clock of an SPI master from the module clock. Software picks one of two laws with a single mode bit. The linear law divides by an even number, 2*(N+1), where N is an 8-bit field. The power-of-two law divides by 2^M, where M is a 4-bit field, and it covers ratios that the linear law cannot reach. The serial clock rests at the polarity level while the block is stopped. It runs while `run` is high.

Besides the clock, the block issues two strobes of one module-clock cycle each. One marks each edge where the clock leaves its idle level and the other marks each return to idle. The shift engine uses them to launch and capture bits. Software computes N and M and loads them; the block does not derive them from a target frequency. The block moves no data, so it has no valid/ready interface, and every pin is a plain control or status level.

Top module: `spi_sclk_divider`

## Requirements
- R1: With `lin_mode`=1 each half period of `sclk` lasts N+1 module-clock cycles, where N = `lin_div`. After `run` is first sampled high on rising edge 0, `sclk` toggles after edges N, 2N+1, 3N+2 and so on.
- R2: With `lin_mode`=0 each half period lasts 2^(M-1) module-clock cycles for M = `pow_exp` >= 1. M=0 is treated the same as M=1: the clock toggles on every module-clock edge, which is the fastest a registered output allows.
- R3: `lin_mode`=1 selects the linear law and `lin_mode`=0 selects the power-of-two law. With the same field values, the two settings give different periods.
- R4: The extreme settings hold. N=255 gives a full period of 512 cycles, and M=15 gives a full period of 32768 cycles.
- R5: While reset is asserted or `run` is low, `sclk` equals `cpol` and both strobes are 0. While running, the first half period drives `sclk` to the level opposite `cpol`.
- R6: When `run` goes low, `sclk` returns to `cpol` and both strobes drop in the same cycle, without waiting for a clock edge. The count restarts, so the next run begins with a full first half period.
- R7: Changes to `lin_div`, `pow_exp` or `lin_mode` while running take effect only for the half period that begins after the next toggle. While stopped, any change takes effect for the next run.
- R8: `lead_stb` is high for exactly the one cycle after `sclk` leaves `cpol`. `trail_stb` is high for exactly the one cycle after `sclk` returns to `cpol`. Neither strobe is ever high while `run` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Divider enable; low stops and idles the clock |
| lin_mode | input | 1 | 1 = linear law, 0 = power-of-two law |
| lin_div | input | 8 | N for the linear law |
| pow_exp | input | 4 | M for the power-of-two law |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle pulse after each edge away from idle |
| trail_stb | output | 1 | One-cycle pulse after each edge back to idle |

## Verification
Random runs draw the law, N, M and `cpol` from a fixed seed. Each run is compared cycle by cycle with a closed-form prediction of the phase and the strobes, which shows that the mode bit picks the law and that each field sets its own half period. Directed cases cover N=0, N=255, M=0 against M=1, and M=15, which pin down the ends of both ranges and the fastest setting. A field change in the middle of a half period separates "takes effect at the boundary" from "takes effect at once". Dropping `run` in the middle of a half period, and then restarting, shows that the idle return is immediate and that the count starts again from zero.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;
  typedef enum logic {
    DIV_POW2   = 1'b0,
    DIV_LINEAR = 1'b1
  } div_mode_e;

  // Counter width able to hold the longest half period of either law.
  function automatic int half_cnt_width(input int lin_w, input int pow_w);
    int pw;
    pw = (1 << pow_w) - 1;
    return ((lin_w > pw) ? lin_w : pw) + 1;
  endfunction
endpackage

// File: rtl/sclk_half_len.sv
module sclk_half_len
  import spi_sclk_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int POW_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             lin_mode,
  input  logic [LIN_W-1:0] lin_div,
  input  logic [POW_W-1:0] pow_exp,
  output logic [CNT_W-1:0] half_len
);
  logic [CNT_W-1:0] lin_len;
  logic [CNT_W-1:0] pow_len;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // Linear: half period of N+1 cycles.
  assign lin_len = CNT_W'(lin_div) + ONE;

  // Power of two: half period of 2^(M-1); M=0 is clamped to one cycle.
  always_comb begin
    if (pow_exp == '0) begin
      pow_len = ONE;
    end else begin
      pow_len = ONE << (pow_exp - POW_W'(1));
    end
  end

  assign half_len = (div_mode_e'(lin_mode) == DIV_LINEAR) ? lin_len : pow_len;
endmodule

// File: rtl/sclk_phase_counter.sv
module sclk_phase_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] next_len,
  output logic             boundary
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic             last;

  assign last     = (cnt_q == len_q - CNT_W'(1));
  assign boundary = run && last;

  // The half length is captured only while stopped or at a toggle, so a
  // field change never cuts a half period short.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= CNT_W'(1);
    end else if (!run) begin
      cnt_q <= '0;
      len_q <= next_len;
    end else if (last) begin
      cnt_q <= '0;
      len_q <= next_len;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sclk_edge_stage.sv
module sclk_edge_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic boundary,
  input  logic cpol,
  output logic sclk,
  output logic lead_stb,
  output logic trail_stb
);
  logic phase_q;
  logic lead_q;
  logic trail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (!run) begin
      phase_q <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      lead_q  <= boundary && !phase_q;
      trail_q <= boundary && phase_q;
      if (boundary) begin
        phase_q <= !phase_q;
      end
    end
  end

  // run gates the registered state so that stopping idles the clock at once.
  assign sclk      = cpol ^ (phase_q & run);
  assign lead_stb  = lead_q & run;
  assign trail_stb = trail_q & run;
endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider
  import spi_sclk_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int POW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             lin_mode,
  input  logic [LIN_W-1:0] lin_div,
  input  logic [POW_W-1:0] pow_exp,
  input  logic             cpol,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb
);
  localparam int CNT_W = half_cnt_width(LIN_W, POW_W);

  logic [CNT_W-1:0] next_len;
  logic             boundary;

  sclk_half_len #(
    .LIN_W(LIN_W),
    .POW_W(POW_W),
    .CNT_W(CNT_W)
  ) u_len (
    .lin_mode(lin_mode),
    .lin_div (lin_div),
    .pow_exp (pow_exp),
    .half_len(next_len)
  );

  sclk_phase_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .next_len(next_len),
    .boundary(boundary)
  );

  sclk_edge_stage u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .boundary (boundary),
    .cpol     (cpol),
    .sclk     (sclk),
    .lead_stb (lead_stb),
    .trail_stb(trail_stb)
  );
endmodule

// File: rtl/spi_sclk_divider_checker.sv
module spi_sclk_divider_checker (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic cpol,
  input logic sclk,
  input logic lead_stb,
  input logic trail_stb
);
  // R8: the two strobes never coincide
  p_strobes_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb));

  // R8: a leading strobe lasts a single cycle
  p_lead_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |=> !lead_stb);

  // R8: a trailing strobe lasts a single cycle
  p_trail_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |=> !trail_stb);

  // R8: a leading strobe follows a move away from idle
  p_lead_after_leave_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |-> (sclk != cpol) && ($past(sclk) == $past(cpol)));

  // R8: any clock movement while running with fixed polarity carries a strobe
  p_move_has_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $stable(cpol) && (sclk != $past(sclk)))
      |-> (lead_stb || trail_stb));

  // R6: stopping idles the clock in the same cycle
  p_idle_on_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> (sclk == cpol) && !lead_stb && !trail_stb);
endmodule

bind spi_sclk_divider spi_sclk_divider_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .cpol     (cpol),
  .sclk     (sclk),
  .lead_stb (lead_stb),
  .trail_stb(trail_stb)
);

// File: tb/spi_sclk_divider_test.sv
module spi_sclk_divider_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       run;
  logic       lin_mode;
  logic [7:0] lin_div;
  logic [3:0] pow_exp;
  logic       cpol;
  logic       sclk;
  logic       lead_stb;
  logic       trail_stb;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  always #2.5 clk = ~clk;

  spi_sclk_divider uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .lin_mode (lin_mode),
    .lin_div  (lin_div),
    .pow_exp  (pow_exp),
    .cpol     (cpol),
    .sclk     (sclk),
    .lead_stb (lead_stb),
    .trail_stb(trail_stb)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      failures = failures + 1;
      checks   = checks + 1;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", cycles, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int half_of(input bit lin, input int n, input int m);
    if (lin) return n + 1;
    if (m == 0) return 1;
    return 1 << (m - 1);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Set the fields and let the divider capture them while stopped.
  task automatic setup(input bit lin, input int n, input int m, input bit pol);
    @(negedge clk);
    run      = 1'b0;
    lin_mode = lin;
    lin_div  = 8'(n);
    pow_exp  = 4'(m);
    cpol     = pol;
    @(negedge clk);
    @(negedge clk);
    chk("R5", "idle sclk", sclk, pol);
    chk("R5", "idle strobes", {30'd0, lead_stb, trail_stb}, 0);
  endtask

  // Run for ncyc edges, checking phase and strobes each cycle, then stop.
  task automatic run_check(input string req, input int h, input int ncyc);
    int bad;
    bit pol;
    pol = cpol;
    bad = 0;
    run = 1'b1;
    for (int t = 0; t < ncyc; t++) begin
      int k;
      bit ph;
      bit el;
      bit et;
      @(posedge clk);
      @(negedge clk);
      k  = (t + 1) / h;
      ph = k[0];
      el = ((t + 1) % h == 0) && ph;
      et = ((t + 1) % h == 0) && !ph;
      if (bad < 3) begin
        chk(req, $sformatf("sclk t=%0d h=%0d", t, h), sclk, int'(pol ^ ph));
        chk("R8", $sformatf("lead_stb t=%0d", t), lead_stb, el);
        chk("R8", $sformatf("trail_stb t=%0d", t), trail_stb, et);
        if ((sclk != (pol ^ ph)) || (lead_stb != el) || (trail_stb != et)) bad++;
      end
    end
    run = 1'b0;
    #1;
    chk("R6", "sclk idle at stop", sclk, pol);
    chk("R6", "strobes idle at stop", {30'd0, lead_stb, trail_stb}, 0);
  endtask

  initial begin
    void'($urandom(32'd24680));
    rst_n    = 1'b0;
    run      = 1'b0;
    lin_mode = 1'b1;
    lin_div  = 8'd0;
    pow_exp  = 4'd0;
    cpol     = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5", "sclk in reset", sclk, 1);
    chk("R5", "strobes in reset", {30'd0, lead_stb, trail_stb}, 0);
    rst_n = 1'b1;

    // R1: fastest and slowest linear settings (R4 for N=255)
    setup(1'b1, 0, 0, 1'b0);
    run_check("R1", half_of(1'b1, 0, 0), 8);
    setup(1'b1, 255, 0, 1'b1);
    run_check("R4", half_of(1'b1, 255, 0), 2 * 256 + 2);

    // R2: M=0 behaves as M=1
    setup(1'b0, 0, 0, 1'b0);
    run_check("R2", half_of(1'b0, 0, 0), 6);
    setup(1'b0, 0, 1, 1'b1);
    run_check("R2", half_of(1'b0, 0, 1), 6);
    // R4: M=15 gives 32768-cycle period
    setup(1'b0, 0, 15, 1'b0);
    run_check("R4", half_of(1'b0, 0, 15), 2 * 16384 + 2);

    // R3: same fields, each mode bit value
    setup(1'b1, 5, 3, 1'b0);
    run_check("R3", half_of(1'b1, 5, 3), 26);
    setup(1'b0, 5, 3, 1'b0);
    run_check("R3", half_of(1'b0, 5, 3), 26);

    // R7: change N from 3 to 0 in the middle of the first half period
    setup(1'b1, 3, 0, 1'b0);
    run = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    lin_div = 8'd0;
    @(posedge clk); @(negedge clk);
    chk("R7", "sclk t=2 old length kept", sclk, 0);
    @(posedge clk); @(negedge clk);
    chk("R7", "sclk t=3 first toggle", sclk, 1);
    @(posedge clk); @(negedge clk);
    chk("R7", "sclk t=4 new length", sclk, 0);
    @(posedge clk); @(negedge clk);
    chk("R7", "sclk t=5 new length", sclk, 1);
    chk("R8", "lead t=5", lead_stb, 1);
    // R6: stop while sclk is active, then restart fresh with N=2
    run = 1'b0;
    #1;
    chk("R6", "sclk idle mid-half", sclk, 0);
    chk("R6", "lead dropped", lead_stb, 0);
    @(negedge clk);
    lin_div = 8'd2;
    @(negedge clk);
    run_check("R6", 3, 12);

    // Random runs against the closed-form prediction
    for (int i = 0; i < 14; i++) begin
      bit lin;
      int n;
      int m;
      bit pol;
      int h;
      lin = 1'($urandom_range(0, 1));
      n   = int'($urandom_range(0, 255));
      m   = int'($urandom_range(0, 9));
      pol = 1'($urandom_range(0, 1));
      h   = half_of(lin, n, m);
      setup(lin, n, m, pol);
      run_check(lin ? "R1" : "R2", h, 3 * h + 4);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule